// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

Two edge counters of one byte each watch two input pins. Each pin passes through a two-flop synchroniser and an edge detector whose polarity is chosen per lane. In split mode the lanes count on their own, each gated by its own enable bit. A single cascade bit joins them into one 16-bit accumulator. That accumulator counts edges of lane 0's pin, which is the pin shared with input-capture channel 0. The upper byte advances on the carry out of the lower byte, and the lane enables are then ignored.

When the 16-bit count wraps, an overflow flag sets. The flag is cleared by writing a one to it. When the interrupt enable is set, the flag drives an interrupt request.

Software reaches four byte-wide registers through a small write port and a combinational read port:
- Address 0, control: bit 6 is cascade enable and bit 1 is overflow-interrupt enable.
- Address 1, lane setup: bits 1:0 are the enables of lane 1 and lane 0, bits 5:4 are the polarities of lane 1 and lane 0, and bit 7 is the overflow flag.
- Address 2: count of lane 0, which is the low byte in cascade.
- Address 3: count of lane 1, which is the high byte in cascade.

Top module: `dual_edge_accum`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: Control (address 0) keeps only bit 6 (cascade) and bit 1 (interrupt enable). Every other bit reads 0. Lane setup (address 1) keeps bits 0, 1, 4 and 5, and bit 7 shows the overflow flag.
- R3: With cascade clear, a lane counts a detected edge only while its enable bit is set. Lane 0's enable is address 1 bit 0 and lane 1's enable is bit 1.
- R4: Polarity bit 0 counts rising edges and polarity bit 1 counts falling edges. Lane 0's polarity is address 1 bit 4 and lane 1's is bit 5. A pin change made between clock edges shows in the count after the third rising clock edge, and not after the second.
- R5: With cascade set, lane 0's pin drives the 16-bit count. The upper byte advances when the lower byte steps from 0xFF to 0x00. Edges on lane 1's pin have no effect.
- R6: With cascade set, both lane enable bits are ignored.
- R7: The overflow flag sets when the cascaded count steps from 0xFFFF to 0x0000. A wrap of a single lane in split mode leaves the flag clear.
- R8: Writing address 1 with bit 7 at 1 clears the flag. Writing bit 7 at 0 leaves the flag unchanged.
- R9: `irq` is high exactly when the flag is set and the interrupt enable is set.
- R10: A write to a count register loads that byte. It wins over an increment of the same byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data of the selected register |
| pin0 | input | 1 | Lane 0 input, shared with capture channel 0 |
| pin1 | input | 1 | Lane 1 input |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench preloads the cascaded count to 0xFFFF and applies one edge. A design that forgets the carry leaves the high byte stuck, and one that sets the flag on a lane-0 wrap alone shows it in the split-mode wrap test. It lines up a count write with a detected edge in the same cycle, so a design that gives the increment priority reads one above the written value. It probes latency at the second and third clock edges and applies half pulses under falling polarity, which exposes a missing synchroniser stage or a swapped polarity. Cascade vectors with both enables set and edges on lane 1's pin catch a design that still honours the enables or counts the wrong pin.

// File: rtl/dual_edge_accum.sv
module dual_edge_accum #(
  parameter int CNT_W    = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             pin0,
  input  logic             pin1,
  output logic             irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LANE = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [1:0] A_HI   = 2'd3;
  localparam int B_CASC = 6;
  localparam int B_IE   = 1;
  localparam int B_FLAG = 7;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [SYNC_LEN:0] sh0, sh1;
  logic              casc_q, ie_q, flag_q;
  logic [1:0]        en_q, pol_q;
  logic [CNT_W-1:0]  cnt0_q, cnt1_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh0 <= '0;
      sh1 <= '0;
    end else begin
      sh0 <= {sh0[SYNC_LEN-1:0], pin0};
      sh1 <= {sh1[SYNC_LEN-1:0], pin1};
    end

  wire ev0 = pol_q[0] ? (sh0[SYNC_LEN] & ~sh0[SYNC_LEN-1]) : (~sh0[SYNC_LEN] & sh0[SYNC_LEN-1]);
  wire ev1 = pol_q[1] ? (sh1[SYNC_LEN] & ~sh1[SYNC_LEN-1]) : (~sh1[SYNC_LEN] & sh1[SYNC_LEN-1]);

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_lane = wr_en && addr == A_LANE;
  wire wr_lo   = wr_en && addr == A_LO;
  wire wr_hi   = wr_en && addr == A_HI;

  wire inc0  = ev0 & (casc_q | en_q[0]);
  wire carry = casc_q & inc0 & (cnt0_q == TOP) & ~wr_lo;
  wire inc1  = casc_q ? carry : (ev1 & en_q[1]);
  wire wrap  = casc_q & inc1 & (cnt1_q == TOP) & ~wr_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      casc_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= '0;
      pol_q  <= '0;
      flag_q <= 1'b0;
      cnt0_q <= '0;
      cnt1_q <= '0;
    end else begin
      if (wr_ctrl) begin
        casc_q <= wr_data[B_CASC];
        ie_q   <= wr_data[B_IE];
      end
      if (wr_lane) begin
        en_q  <= wr_data[1:0];
        pol_q <= wr_data[5:4];
      end
      if (wrap)                           flag_q <= 1'b1;
      else if (wr_lane && wr_data[B_FLAG]) flag_q <= 1'b0;
      if (wr_lo)      cnt0_q <= wr_data;
      else if (inc0)  cnt0_q <= cnt0_q + 1'b1;
      if (wr_hi)      cnt1_q <= wr_data;
      else if (inc1)  cnt1_q <= cnt1_q + 1'b1;
    end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: begin
        rd_data[B_CASC] = casc_q;
        rd_data[B_IE]   = ie_q;
      end
      A_LANE: begin
        rd_data[1:0]    = en_q;
        rd_data[5:4]    = pol_q;
        rd_data[B_FLAG] = flag_q;
      end
      A_LO:    rd_data = cnt0_q;
      default: rd_data = cnt1_q;
    endcase
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/dual_edge_accum_chk.sv
module dual_edge_accum_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             casc_q,
  input logic [1:0]       en_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt0_q,
  input logic [CNT_W-1:0] cnt1_q
);
  a_r3_idle_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_q && !en_q[0] && !wr_en) |=> $stable(cnt0_q));

  a_r5_high_moves_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(casc_q) && !$past(wr_en) && cnt1_q != $past(cnt1_q))
      |-> ($past(cnt0_q) == '1 && cnt0_q == '0));

  a_r7_flag_from_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(casc_q) && $past(cnt0_q) == '1 && $past(cnt1_q) == '1));

  a_r8_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_en && addr == 2'd1 && wr_data[7]));

  a_r10_low_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (cnt0_q == $past(wr_data)));
endmodule

bind dual_edge_accum dual_edge_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .casc_q(casc_q), .en_q(en_q), .flag_q(flag_q), .cnt0_q(cnt0_q), .cnt1_q(cnt1_q)
);

// File: tb/dual_edge_accum_bench.sv
module dual_edge_accum_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {ctrl, lane setup, pulses pin0, pulses pin1, expected lo, expected hi}
  localparam logic [47:0] VEC [NV] = '{
    {8'h00, 8'h03, 8'd3, 8'd5, 8'd3, 8'd5},
    {8'h00, 8'h01, 8'd4, 8'd4, 8'd4, 8'd0},
    {8'h00, 8'h02, 8'd2, 8'd6, 8'd0, 8'd6},
    {8'h00, 8'h33, 8'd3, 8'd2, 8'd3, 8'd2},
    {8'h40, 8'h00, 8'd7, 8'd9, 8'd7, 8'd0},
    {8'h40, 8'h03, 8'd5, 8'd1, 8'd5, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pin0 = 1'b0, pin1 = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data, v;
  logic irq;
  int applied = 0, miscompares = 0;

  dual_edge_accum u_dual_edge_accum (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pin0(pin0), .pin1(pin1), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 register reset", v, 8'h00);
    end
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    wr(0, 8'hFF); rd(0, v); check("R2 control layout", v, 8'h42);
    wr(1, 8'h7F); rd(1, v); check("R2 lane layout", v, 8'h33);

    for (int k = 0; k < NV; k++) begin
      logic [47:0] t = VEC[k];
      int mx = (t[31:24] > t[23:16]) ? int'(t[31:24]) : int'(t[23:16]);
      wr(0, t[47:40]); wr(1, t[39:32]); wr(2, 8'h00); wr(3, 8'h00);
      for (int p = 0; p < mx; p++) begin
        pin0 = (p < t[31:24]); pin1 = (p < t[23:16]);
        waitc(2);
        pin0 = 1'b0; pin1 = 1'b0;
        waitc(2);
      end
      waitc(4);
      rd(2, v); check("R3 R4 R5 R6 vector low count", v, t[15:8]);
      rd(3, v); check("R3 R5 R6 vector high count", v, t[7:0]);
    end

    // R4 latency and falling polarity
    wr(0, 8'h00); wr(1, 8'h11); wr(2, 8'h00);
    @(negedge clk); pin0 = 1'b1;
    waitc(4); rd(2, v); check("R4 falling ignores rise", v, 8'h00);
    wr(1, 8'h01);
    @(negedge clk); pin0 = 1'b0;
    waitc(2); rd(2, v); check("R4 no rise counted on fall", v, 8'h00);
    @(negedge clk); pin0 = 1'b1;
    @(negedge clk); @(negedge clk); #1 check("R4 not visible after two edges", rd_data, 8'h00);
    @(negedge clk); #1 check("R4 visible after three edges", rd_data, 8'h01);
    pin0 = 1'b0; waitc(4);

    // R5 carry
    wr(0, 8'h40); wr(1, 8'h00); wr(2, 8'hFE); wr(3, 8'h00);
    for (int p = 0; p < 3; p++) begin
      pin0 = 1'b1; waitc(2); pin0 = 1'b0; waitc(2);
    end
    waitc(4);
    rd(2, v); check("R5 low after carry", v, 8'h01);
    rd(3, v); check("R5 high after carry", v, 8'h01);

    // R7 R8 R9 overflow
    wr(2, 8'hFF); wr(3, 8'hFF);
    pin0 = 1'b1; waitc(2); pin0 = 1'b0; waitc(4);
    rd(2, v); check("R7 low wraps", v, 8'h00);
    rd(3, v); check("R7 high wraps", v, 8'h00);
    rd(1, v); check("R7 flag set", v, 8'h80);
    check("R9 irq held off", {7'b0, irq}, 8'h00);
    wr(0, 8'h42); #1 check("R9 irq raised", {7'b0, irq}, 8'h01);
    wr(1, 8'h00); rd(1, v); check("R8 zero write keeps flag", v, 8'h80);
    wr(1, 8'h80); rd(1, v); check("R8 flag cleared", v, 8'h00);
    #1 check("R9 irq dropped", {7'b0, irq}, 8'h00);

    // R7 split wrap
    wr(0, 8'h02); wr(1, 8'h01); wr(2, 8'hFF); wr(3, 8'h00);
    pin0 = 1'b1; waitc(2); pin0 = 1'b0; waitc(4);
    rd(2, v); check("R7 split low wraps", v, 8'h00);
    rd(3, v); check("R7 split high untouched", v, 8'h00);
    rd(1, v); check("R7 split no flag", v, 8'h01);

    // R10 write beats increment
    wr(2, 8'h10);
    @(negedge clk); pin0 = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 2'd2; wr_data = 8'h55; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    waitc(3);
    rd(2, v); check("R10 write wins", v, 8'h55);
    pin0 = 1'b0; waitc(4);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule